// File: doc/BRIEF.md
# Triggered Sample Clock Sequencer

This block produces a sample clock for a data-acquisition engine. It divides a timebase tick by a programmable divisor and gates the result with three controls. A start trigger arms an acquisition. A level-sensitive pause holds the clock while it is at its programmed active level. A finite-mode sample counter ends the acquisition after the requested number of samples. In continuous mode the acquisition runs until a stop request arrives.

When a start trigger is accepted, the block latches the divisor, the start delay, the sample count and the mode. It then waits the programmed number of unpaused timebase ticks before it emits the first sample pulse. Every later pulse follows a fixed number of unpaused ticks after the previous one. The block echoes an accepted start as a one-cycle pulse. It exports each sample pulse twice: once active-high and once as an active-low convert strobe. It flags a bad configuration instead of starting.

Top module: `tscSampleSequencer`

## Requirements
- R1: While running, consecutive sample pulses are separated by exactly `divisorIn` unpaused timebase ticks, using the divisor latched at the accepted start.
- R2: The first sample pulse appears one clock after the D-th unpaused tick that follows the accept edge. D is `delayIn`, and a `delayIn` of 0 selects D = 2. The tick seen in the accept cycle itself is not counted.
- R3: A tick with the pause asserted at its active level is not counted. The level is active when `pauseIn` equals `pauseActiveHigh` (1 = active high, 0 = active low). Pausing moves every following pulse later and drops none.
- R4: In finite mode (`finiteMode`=1) exactly `countIn` pulses are emitted. `done` is high for one cycle together with the last pulse, and the block then returns to idle.
- R5: In continuous mode (`finiteMode`=0) pulses continue until `stopIn` is high. A tick in a cycle with `stopIn` high produces no pulse, the block goes idle, and `done` is never raised.
- R6: A rising edge on `startIn` while an acquisition is in its delay or run phase is ignored: no echo, and the pulse timing is unchanged.
- R7: A start edge seen while idle is rejected if `divisorIn` < 2, or if finite mode has `countIn` = 0. On rejection `error` rises, no echo is given and no pulses follow. `error` stays high until a valid start is accepted, which clears it.
- R8: An accepted start (a rising edge on `startIn` while idle with a valid configuration) gives `startEcho` high for exactly the next cycle.
- R9: `convClkN` is low exactly in the cycles where `sampleClk` is high, and is high otherwise.
- R10: Changes to `divisorIn`, `delayIn`, `countIn` or `finiteMode` after the accept edge do not affect the running acquisition.
- R11: During reset `sampleClk`, `startEcho`, `done` and `error` are 0 and `convClkN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tbTick | input | 1 | Timebase tick enable, one cycle per tick |
| startIn | input | 1 | Start trigger level; rising edge arms |
| stopIn | input | 1 | Stop request, ends an acquisition |
| pauseIn | input | 1 | Pause trigger level |
| pauseActiveHigh | input | 1 | Pause polarity: 1 active high, 0 active low |
| finiteMode | input | 1 | 1 finite, 0 continuous |
| divisorIn | input | DIV_W | Ticks between samples |
| delayIn | input | DLY_W | Ticks from start to first sample, 0 selects 2 |
| countIn | input | CNT_W | Samples in a finite acquisition |
| sampleClk | output | 1 | Active-high sample pulse |
| convClkN | output | 1 | Active-low copy of the sample pulse |
| startEcho | output | 1 | One-cycle echo of an accepted start |
| done | output | 1 | One-cycle end of a finite acquisition |
| error | output | 1 | Rejected configuration flag |

## Verification
Several properties are checked on every clock cycle. Pulses are never back to back. The convert strobe is always the inverse of the sample pulse. Every pulse follows an unpaused tick. `done` coincides with a pulse and with a return to idle. The error flag and the start echo keep their single-cycle and idle-only shape. Only the bench scenarios can show the exact pulse positions: the delay count, including the default of 2, the spacing set by the divisor, the push-back caused by a pause under either polarity, the exact sample count, the retrigger being ignored, the latched configuration and the behaviour of the stop request. The bench sweeps divisor, delay, count, tick rate, pause polarity and pause window, and predicts each pulse arithmetically from a running count of unpaused ticks.

// File: rtl/tscSeqPkg.sv
package tscSeqPkg;
  localparam int unsigned MinDivisor   = 2;
  localparam int unsigned DefaultDelay = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // accepted start: latch configuration
    logic delayTick;  // counted tick in the delay phase
    logic runTick;    // counted tick in the run phase
    logic fire;       // emit a sample this cycle
  } seqStrobe_t;
endpackage

// File: rtl/tscDatapath.sv
module tscDatapath
  import tscSeqPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DIV_W-1:0] divisorIn,
  input  logic [DLY_W-1:0] delayIn,
  input  logic [CNT_W-1:0] countIn,
  output logic             delayHit,
  output logic             divHit,
  output logic             lastHit,
  output logic             sampleClk,
  output logic             convClkN
);
  localparam logic [DLY_W-1:0] DlyDefault = DLY_W'(DefaultDelay);

  logic [DIV_W-1:0] divReg;
  logic [DLY_W-1:0] dlyReg;
  logic [CNT_W-1:0] remaining;
  logic [DLY_W-1:0] delCnt;
  logic [DIV_W-1:0] divCnt;

  assign delayHit = ({1'b0, delCnt} + 1'b1) == {1'b0, dlyReg};
  assign divHit   = ({1'b0, divCnt} + 1'b1) == {1'b0, divReg};
  assign lastHit  = remaining == CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg    <= '0;
      dlyReg    <= '0;
      remaining <= '0;
      delCnt    <= '0;
      divCnt    <= '0;
    end else if (strobe.load) begin
      divReg    <= divisorIn;
      dlyReg    <= (delayIn == '0) ? DlyDefault : delayIn;
      remaining <= countIn;
      delCnt    <= '0;
      divCnt    <= '0;
    end else begin
      if (strobe.delayTick && !delayHit) delCnt <= delCnt + 1'b1;
      if (strobe.fire) begin
        divCnt <= '0;
        if (remaining != '0) remaining <= remaining - 1'b1;
      end else if (strobe.runTick) begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleClk <= 1'b0;
      convClkN  <= 1'b1;
    end else begin
      sampleClk <= strobe.fire;
      convClkN  <= ~strobe.fire;
    end
  end

  // R9: exported strobe is the inverse of the sample pulse
  p_conv_inverse_r9: assert property (@(posedge clk) disable iff (!rstN)
    convClkN == !sampleClk);

  // R1: divisor of at least two never yields back-to-back pulses
  p_sample_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    sampleClk |=> !sampleClk);
endmodule

// File: rtl/tscControl.sv
module tscControl
  import tscSeqPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tbTick,
  input  logic             startIn,
  input  logic             stopIn,
  input  logic             pauseIn,
  input  logic             pauseActiveHigh,
  input  logic             finiteMode,
  input  logic [DIV_W-1:0] divisorIn,
  input  logic [CNT_W-1:0] countIn,
  input  logic             delayHit,
  input  logic             divHit,
  input  logic             lastHit,
  output seqStrobe_t       strobe,
  output logic             startEcho,
  output logic             done,
  output logic             error
);
  seqState_e state, stateNext;
  logic startPrev, finiteReg;
  logic startEdge, paused, effTick, badCfg, accept, reject, endFinite;

  assign startEdge = startIn & ~startPrev;
  assign paused    = pauseActiveHigh ? pauseIn : ~pauseIn;
  assign effTick   = tbTick & ~paused;
  assign badCfg    = (divisorIn < DIV_W'(MinDivisor)) || (finiteMode && countIn == '0);
  assign accept    = (state == ST_IDLE) && startEdge && !badCfg;
  assign reject    = (state == ST_IDLE) && startEdge && badCfg;

  always_comb begin
    strobe.load      = accept;
    strobe.delayTick = (state == ST_DELAY) && effTick && !stopIn;
    strobe.runTick   = (state == ST_RUN) && effTick && !stopIn;
    strobe.fire      = (strobe.delayTick && delayHit) || (strobe.runTick && divHit);
  end

  assign endFinite = strobe.fire && finiteReg && lastHit;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = ST_DELAY;
      ST_DELAY: begin
        if (stopIn || endFinite) stateNext = ST_IDLE;
        else if (strobe.fire)    stateNext = ST_RUN;
      end
      ST_RUN:   if (stopIn || endFinite) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startPrev <= 1'b0;
      finiteReg <= 1'b0;
      startEcho <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      state     <= stateNext;
      startPrev <= startIn;
      startEcho <= accept;
      done      <= endFinite;
      if (accept) finiteReg <= finiteMode;
      if (reject)      error <= 1'b1;
      else if (accept) error <= 1'b0;
    end
  end

  // R7: error only stands while no acquisition is active
  p_error_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    error |-> state == ST_IDLE);

  // R4: completion returns the sequencer to idle
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> state == ST_IDLE);

  // R8: echo lasts one cycle
  p_echo_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    startEcho |=> !startEcho);
endmodule

// File: rtl/tscSampleSequencer.sv
module tscSampleSequencer
  import tscSeqPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tbTick,
  input  logic             startIn,
  input  logic             stopIn,
  input  logic             pauseIn,
  input  logic             pauseActiveHigh,
  input  logic             finiteMode,
  input  logic [DIV_W-1:0] divisorIn,
  input  logic [DLY_W-1:0] delayIn,
  input  logic [CNT_W-1:0] countIn,
  output logic             sampleClk,
  output logic             convClkN,
  output logic             startEcho,
  output logic             done,
  output logic             error
);
  seqStrobe_t strobe;
  logic delayHit, divHit, lastHit;

  tscControl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .startIn(startIn), .stopIn(stopIn),
    .pauseIn(pauseIn), .pauseActiveHigh(pauseActiveHigh), .finiteMode(finiteMode),
    .divisorIn(divisorIn), .countIn(countIn), .delayHit(delayHit), .divHit(divHit),
    .lastHit(lastHit), .strobe(strobe), .startEcho(startEcho), .done(done), .error(error)
  );

  tscDatapath #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divisorIn(divisorIn), .delayIn(delayIn),
    .countIn(countIn), .delayHit(delayHit), .divHit(divHit), .lastHit(lastHit),
    .sampleClk(sampleClk), .convClkN(convClkN)
  );

  // R3: every pulse follows an unpaused timebase tick
  p_pause_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleClk |-> $past(tbTick) && ($past(pauseIn) != $past(pauseActiveHigh)));

  // R4: completion coincides with the final pulse
  p_done_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sampleClk);
endmodule

// File: tb/tscSampleSequencer_test.sv
module tscSampleSequencer_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tbTick = 0, startIn = 0, stopIn = 0, pauseIn = 0, pauseActiveHigh = 1, finiteMode = 1;
  logic [7:0]  divisorIn = 8'd2;
  logic [7:0]  delayIn = 8'd1;
  logic [15:0] countIn = 16'd1;
  logic sampleClk, convClkN, startEcho, done, error;

  int nChecks = 0;
  int nFail = 0;

  always #(ClkPeriod/2) clk = ~clk;

  tscSampleSequencer uut (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .startIn(startIn), .stopIn(stopIn),
    .pauseIn(pauseIn), .pauseActiveHigh(pauseActiveHigh), .finiteMode(finiteMode),
    .divisorIn(divisorIn), .delayIn(delayIn), .countIn(countIn),
    .sampleClk(sampleClk), .convClkN(convClkN), .startEcho(startEcho),
    .done(done), .error(error)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // start edge: low for a cycle, then high; samples outputs after the accept edge
  task automatic pulseStart();
    startIn = 1'b0;
    tbTick  = 1'b0;
    @(negedge clk);
    startIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic runFinite(input int div, input int dly, input int cnt, input int per,
                           input int pol, input int usePause);
    int dEff = (dly == 0) ? 2 : dly;
    int k = 0;
    int idx = 0;
    int tail = 0;
    bit retrig = 0;
    pauseActiveHigh = pol[0];
    pauseIn   = ~pol[0];
    finiteMode = 1'b1;
    divisorIn = 8'(div);
    delayIn   = 8'(dly);
    countIn   = 16'(cnt);
    pulseStart();
    check("R8", "echo on accept", int'(startEcho), 1);
    check("R7", "error after valid start", int'(error), 0);
    for (int t = 1; t < 200 && tail < 3; t++) begin
      bit tick = (t % per) == 0;
      bit pa = (usePause != 0) && t >= 3 && t < 7;
      bit eff;
      bit expS = 0;
      bit expD = 0;
      if (t == 3) retrig = idx < cnt;
      startIn = (t == 2) ? 1'b0 : ((t >= 3) ? retrig : 1'b1);
      pauseIn = pol[0] ? pa : ~pa;
      tbTick  = tick;
      if (t == 4) begin divisorIn = 8'd1; delayIn = 8'd9; countIn = 16'd0; end // R10
      eff = tick && !pa && idx < cnt;
      if (eff) begin
        k++;
        if (k >= dEff && ((k - dEff) % div) == 0) begin
          expS = 1;
          expD = (idx == cnt - 1);
          idx++;
        end
      end
      if (idx == cnt && !expS) tail++;
      @(negedge clk);
      check("R1/R2/R3/R10", "sampleClk", int'(sampleClk), int'(expS));
      check("R9", "convClkN", int'(convClkN), int'(!expS));
      check("R4", "done", int'(done), int'(expD));
      check("R6", "no echo on retrigger", int'(startEcho), 0);
    end
    startIn = 1'b0;
    tbTick  = 1'b0;
  endtask

  initial begin
    #(ClkPeriod * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "sampleClk in reset", int'(sampleClk), 0);
    check("R11", "convClkN in reset", int'(convClkN), 1);
    check("R11", "startEcho in reset", int'(startEcho), 0);
    check("R11", "done in reset", int'(done), 0);
    check("R11", "error in reset", int'(error), 0);
    rstN = 1'b1;
    @(negedge clk);

    // finite sweep
    for (int div = 2; div <= 4; div++)
      for (int dly = 0; dly <= 3; dly++)
        for (int cnt = 1; cnt <= 3; cnt++)
          for (int per = 1; per <= 2; per++)
            for (int pol = 0; pol <= 1; pol++)
              for (int up = 0; up <= 1; up++)
                runFinite(div, dly, cnt, per, pol, up);

    // continuous mode, R5, with config change mid-run (R10)
    begin
      int k = 0;
      pauseActiveHigh = 1'b1;
      pauseIn = 1'b0;
      finiteMode = 1'b0;
      divisorIn = 8'd3;
      delayIn = 8'd2;
      countIn = 16'd0;
      pulseStart();
      check("R8", "echo continuous", int'(startEcho), 1);
      for (int t = 1; t <= 31; t++) begin
        bit expS = 0;
        tbTick = 1'b1;
        stopIn = (t >= 23 && t <= 27);
        if (t == 5) divisorIn = 8'd9;
        if (t < 23) begin
          k++;
          expS = k >= 2 && ((k - 2) % 3) == 0;
        end
        @(negedge clk);
        check("R5", "continuous sampleClk", int'(sampleClk), int'(expS));
        check("R5", "continuous done", int'(done), 0);
      end
      stopIn = 1'b0;
      tbTick = 1'b0;
    end

    // rejected configurations, R7
    finiteMode = 1'b1;
    countIn = 16'd3;
    delayIn = 8'd1;
    for (int bad = 0; bad < 3; bad++) begin
      divisorIn = (bad < 2) ? 8'(bad) : 8'd3;
      countIn   = (bad < 2) ? 16'd3 : 16'd0;
      pulseStart();
      check("R7", "error on reject", int'(error), 1);
      check("R7", "no echo on reject", int'(startEcho), 0);
      for (int t = 0; t < 8; t++) begin
        tbTick = 1'b1;
        @(negedge clk);
        check("R7", "no sample after reject", int'(sampleClk), 0);
        check("R7", "error held", int'(error), 1);
      end
    end
    divisorIn = 8'd2;
    countIn = 16'd1;
    delayIn = 8'd1;
    pulseStart();
    check("R7", "error cleared by valid start", int'(error), 0);
    check("R8", "echo after recovery", int'(startEcho), 1);
    tbTick = 1'b1;
    @(negedge clk);
    check("R4", "single sample", int'(sampleClk), 1);
    check("R4", "single done", int'(done), 1);
    @(negedge clk);
    check("R8", "echo ends", int'(startEcho), 0);
    tbTick = 1'b0;
    startIn = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule